// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Receive Store

This block sits behind a T1 frame aligner. It watches the received channel bytes and keeps 24 receive signaling registers, one for each DS0 channel. Each channel has a two-bit signaling mode, so voice channels with 2-, 4- or 16-state signaling can share a frame with clear data channels. In robbed-bit operation, the least significant bit of a channel byte carries a signaling bit in every sixth frame. The block gathers these bits over a superframe and writes the channel's register once the channel's last bit has arrived.

In common-channel mode the per-channel modes are ignored. The whole byte of the last channel is stored instead, with frame k of the superframe going into register k.

Register updates stop whenever frame or superframe alignment is missing, and whenever software asks for a hold. They also stop through a self-triggered hold. A framing error, a controlled slip or any loss of alignment loads a 32-frame counter. A new trigger while the counter is running reloads it.

Top module: `rbs_rx_store`

## Requirements
- R1: After reset all 24 registers read zero. Register k appears on `sig_o[8k+7:8k]`.
- R2: Channel k takes its mode from `fg_cfg_i[2k+1:2k]`. The encodings are: 00 clear data, with the register never written by robbed-bit capture; 01 two-state (A only); 10 four-state (A, B); 11 sixteen-state (A, B, C, D). The stored layout is A at bit 3, B at bit 2, C at bit 1 and D at bit 0. Bits 7:4 are zero, and any bit the mode does not use is zero.
- R3: The signaling bit is bit 0 of the channel byte. Zero-based `frame_i` values 5, 11, 17 and 23 carry A, B, C and D. With `esf_i`=1 the superframe has 24 frames. With `esf_i`=0 it has 12 frames, and a sixteen-state channel stores only A and B.
- R4: A channel's register is written at the clock edge that takes the byte carrying the last bit its mode needs. The value holds A..D from that same superframe, and the new value is visible from the next cycle.
- R5: No register changes in a cycle in which `frm_aligned_i` or `sf_aligned_i` is low.
- R6: While `sw_inhibit_i` is high no register changes. Releasing it starts no hold.
- R7: `frame_err_i`, `slip_i` or lost alignment loads a hold counter to 32. The counter counts down on each valid channel-0 byte. No register changes while it is nonzero. A trigger during a hold reloads the counter to 32.
- R8: With `ccs_i`=1 the modes are ignored and no robbed-bit capture takes place. The channel-23 byte of frame k is stored whole into register k, under the gating of R5 to R7. Registers that receive no frame keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | A channel byte is present this cycle |
| chan_i | input | 5 | Channel index 0..23 of the byte |
| frame_i | input | 5 | Frame index within the superframe, zero-based |
| data_i | input | 8 | Received channel byte |
| esf_i | input | 1 | 1: 24-frame superframe, 0: 12-frame superframe |
| ccs_i | input | 1 | Common-channel signaling mode |
| fg_cfg_i | input | 48 | Two mode bits per channel |
| frm_aligned_i | input | 1 | Frame alignment held |
| sf_aligned_i | input | 1 | Superframe alignment held |
| frame_err_i | input | 1 | Framing error event pulse |
| slip_i | input | 1 | Controlled slip event pulse |
| sw_inhibit_i | input | 1 | Software hold of register updates |
| sig_o | output | 192 | 24 signaling registers, 8 bits each |

## Verification
A wrong hold counter shows up as a robbed-bit frame that was written when it should have been blocked, or blocked when it should have been written. This becomes visible on `sig_o` one cycle after the sixth-frame byte concerned. The directed event placements put the end of the hold between the A and B frames, so a missing reload or an off-by-one count changes specific registers in a known pattern. A wrong bit accumulator or mode decode shows up as a mis-set bit in the register one cycle after the channel's last signaling frame. The bench compares all 24 registers at every frame boundary, so any such error appears within one frame of its cause.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int NUM_CH     = 24;
  localparam int REG_W      = 8;
  localparam int SIG_BITS   = 4;
  localparam int ROB_PERIOD = 6;
  localparam int ESF_FRAMES = 24;
  localparam int INH_FRAMES = 32;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int FR_W       = $clog2(ESF_FRAMES);
  localparam int CNT_W      = $clog2(INH_FRAMES + 1);
  localparam int CCS_CH     = NUM_CH - 1;

  typedef enum logic [1:0] {
    FG_DATA  = 2'b00,
    FG_2ST   = 2'b01,
    FG_4ST   = 2'b10,
    FG_16ST  = 2'b11
  } fg_mode_e;

  // frame index carrying signaling bit j (0=A)
  function automatic logic [FR_W-1:0] rob_frame(input int j);
    return FR_W'(ROB_PERIOD * (j + 1) - 1);
  endfunction

  // index of the last signaling bit a mode needs
  function automatic int last_slot(input logic [1:0] fg, input logic esf);
    case (fg)
      FG_2ST:  return 0;
      FG_4ST:  return 1;
      FG_16ST: return esf ? SIG_BITS - 1 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [SIG_BITS-1:0] fg_mask(input logic [1:0] fg, input logic esf);
    logic [SIG_BITS-1:0] m;
    m = '1;
    m = m << (SIG_BITS - 1 - last_slot(fg, esf));
    return (fg == FG_DATA) ? '0 : m;
  endfunction
endpackage

// File: rtl/rbs_inhibit.sv
module rbs_inhibit
  import rbs_pkg::*;
#(
  parameter int HOLD_FRAMES = INH_FRAMES,
  localparam int HW = $clog2(HOLD_FRAMES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic frame_bnd_i,
  output logic inhibit_o
);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (trig_i)                    cnt_q <= HW'(HOLD_FRAMES);
    else if (frame_bnd_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign inhibit_o = (cnt_q != '0);

  p_trig_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> inhibit_o);
  p_release_on_bnd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inhibit_o) |-> $past(frame_bnd_i));
endmodule

// File: rtl/rbs_chan_store.sv
module rbs_chan_store
  import rbs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_stb_i,
  input  logic [FR_W-1:0]  frame_i,
  input  logic             rob_bit_i,
  input  logic             esf_i,
  input  logic [1:0]       fg_i,
  input  logic             ccs_i,
  input  logic             ccs_wr_i,
  input  logic [REG_W-1:0] ccs_byte_i,
  input  logic             aligned_i,
  input  logic             allow_i,
  output logic [REG_W-1:0] reg_o
);
  logic [SIG_BITS-1:0] acc_q, acc_d;
  logic rob_hit, rob_last, cap, wr_rob;

  always_comb begin
    acc_d   = acc_q;
    rob_hit = 1'b0;
    for (int j = 0; j < SIG_BITS; j++) begin
      if (frame_i == rob_frame(j)) begin
        rob_hit = 1'b1;
        acc_d[SIG_BITS-1-j] = rob_bit_i;
      end
    end
    // A opens a new superframe set
    if (frame_i == rob_frame(0)) acc_d[SIG_BITS-2:0] = '0;
    rob_last = (fg_i != FG_DATA) && (frame_i == rob_frame(last_slot(fg_i, esf_i)));
  end

  assign cap    = byte_stb_i && aligned_i && !ccs_i && rob_hit;
  assign wr_rob = cap && allow_i && rob_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      reg_o <= '0;
    end else begin
      if (cap) acc_q <= acc_d;
      if (ccs_wr_i)    reg_o <= ccs_byte_i;
      else if (wr_rob) reg_o <= REG_W'(acc_d & fg_mask(fg_i, esf_i));
    end
  end

  p_data_chan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ccs_i && fg_i == FG_DATA && !ccs_wr_i) |=> $stable(reg_o));
  p_ccs_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccs_i && !ccs_wr_i) |=> $stable(reg_o));
endmodule

// File: rtl/rbs_rx_store.sv
module rbs_rx_store
  import rbs_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      byte_vld_i,
  input  logic [CH_W-1:0]           chan_i,
  input  logic [FR_W-1:0]           frame_i,
  input  logic [REG_W-1:0]          data_i,
  input  logic                      esf_i,
  input  logic                      ccs_i,
  input  logic [2*NUM_CH-1:0]       fg_cfg_i,
  input  logic                      frm_aligned_i,
  input  logic                      sf_aligned_i,
  input  logic                      frame_err_i,
  input  logic                      slip_i,
  input  logic                      sw_inhibit_i,
  output logic [NUM_CH*REG_W-1:0]   sig_o
);
  logic aligned, trig, hold, allow, frame_bnd;

  assign aligned   = frm_aligned_i && sf_aligned_i;
  assign trig      = frame_err_i || slip_i || !aligned;
  assign frame_bnd = byte_vld_i && (chan_i == '0);
  assign allow     = aligned && !sw_inhibit_i && !trig && !hold;

  rbs_inhibit #(.HOLD_FRAMES(INH_FRAMES)) u_inh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .frame_bnd_i (frame_bnd),
    .inhibit_o   (hold)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic stb, ccs_wr;
    assign stb    = byte_vld_i && (chan_i == CH_W'(k));
    assign ccs_wr = ccs_i && byte_vld_i && (chan_i == CH_W'(CCS_CH))
                    && (frame_i == FR_W'(k)) && allow;

    rbs_chan_store u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .byte_stb_i (stb),
      .frame_i    (frame_i),
      .rob_bit_i  (data_i[0]),
      .esf_i      (esf_i),
      .fg_i       (fg_cfg_i[2*k +: 2]),
      .ccs_i      (ccs_i),
      .ccs_wr_i   (ccs_wr),
      .ccs_byte_i (data_i),
      .aligned_i  (aligned),
      .allow_i    (allow),
      .reg_o      (sig_o[k*REG_W +: REG_W])
    );
  end

  p_align_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned |=> $stable(sig_o));
  p_sw_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_inhibit_i |=> $stable(sig_o));
  p_event_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_i || slip_i) |=> $stable(sig_o));
endmodule

// File: tb/tb_rbs_rx_store.sv
`timescale 1ns/1ps
module tb_rbs_rx_store;
  import rbs_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [CH_W-1:0] ch = '0;
  logic [FR_W-1:0] fr = '0;
  logic [7:0] d = '0;
  logic esf = 1'b1, ccs = 1'b0;
  logic [1:0] fg [NUM_CH];
  logic [2*NUM_CH-1:0] fg_cfg;
  logic fa = 1'b1, sa = 1'b1, ferr = 1'b0, slip = 1'b0, sw = 1'b0;
  logic [NUM_CH*REG_W-1:0] sig;

  int checks = 0, errors = 0;
  logic [7:0] m_reg [NUM_CH];
  logic [3:0] m_acc [NUM_CH];
  int m_cnt = 0;
  int p_ev = 0;

  always #10 clk = ~clk;

  always_comb for (int k = 0; k < NUM_CH; k++) fg_cfg[2*k +: 2] = fg[k];

  rbs_rx_store dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .chan_i(ch), .frame_i(fr),
    .data_i(d), .esf_i(esf), .ccs_i(ccs), .fg_cfg_i(fg_cfg),
    .frm_aligned_i(fa), .sf_aligned_i(sa), .frame_err_i(ferr), .slip_i(slip),
    .sw_inhibit_i(sw), .sig_o(sig)
  );

  function automatic int lastj(input logic [1:0] f, input logic e);
    return (f == 2'b01) ? 0 : (f == 2'b10) ? 1 : (e ? 3 : 1);
  endfunction

  function automatic logic [7:0] exp_ones(input logic [1:0] f, input logic e);
    if (f == 2'b00) return 8'h00;
    return {4'h0, 4'hF << (3 - lastj(f, e))};
  endfunction

  task automatic chk(input string tag, input int k, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s reg%0d actual=%02h expected=%02h", tag, k, act, exp);
    end
  endtask

  task automatic model_step();
    logic al, trg, inh, allow;
    int hit;
    al = fa && sa;
    trg = ferr || slip || !al;
    inh = sw || trg || (m_cnt != 0);
    allow = al && !inh;
    if (vld) begin
      if (ccs) begin
        if (ch == CH_W'(23) && allow && fr < 24) m_reg[fr] = d;
      end else if (al) begin
        hit = -1;
        for (int j = 0; j < 4; j++) if (int'(fr) == 6*(j+1)-1) hit = j;
        if (hit >= 0) begin
          if (hit == 0) m_acc[ch] = {d[0], 3'b000};
          else m_acc[ch][3-hit] = d[0];
          if (allow && fg[ch] != 2'b00 && hit == lastj(fg[ch], esf))
            m_reg[ch] = {4'h0, m_acc[ch] & (4'hF << (3 - lastj(fg[ch], esf)))};
        end
      end
    end
    if (trg) m_cnt = 32;
    else if (vld && ch == '0 && m_cnt > 0) m_cnt--;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
  endtask

  task automatic check_model(input string tag);
    for (int k = 0; k < NUM_CH; k++) chk(tag, k, sig[k*8 +: 8], m_reg[k]);
  endtask

  // dmode: 0 zeros, 1 ones, 2 random, 3 ccs pattern base+frame on ch23
  task automatic run_sf(input int dmode, input logic [7:0] base, input int err_fr, input int err_ch,
                        input int slip_fr, input int slip_ch, input int los_fr, input string tag);
    int nfr;
    nfr = esf ? 24 : 12;
    for (int f = 0; f < nfr; f++) begin
      fa = 1'b1; sa = (f != los_fr);
      if (p_ev > 0 && ($urandom % 100) == 0) begin
        if ($urandom % 2) fa = 1'b0; else sa = 1'b0;
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (p_ev > 0 && ($urandom % 16) == 0) begin
          vld = 1'b0; ferr = 1'b0; slip = 1'b0;
          tick();
        end
        vld = 1'b1; ch = CH_W'(c); fr = FR_W'(f);
        case (dmode)
          0: d = 8'h00;
          1: d = 8'hFF;
          3: d = (c == 23) ? base + 8'(f) : 8'($urandom);
          default: d = 8'($urandom);
        endcase
        ferr = (f == err_fr && c == err_ch) || (p_ev > 0 && ($urandom % 10000) < p_ev);
        slip = (f == slip_fr && c == slip_ch) || (p_ev > 0 && ($urandom % 10000) < p_ev);
        tick();
      end
      ferr = 1'b0; slip = 1'b0;
      check_model(tag);
    end
    fa = 1'b1; sa = 1'b1; vld = 1'b0;
  endtask

  task automatic expect_pattern(input string tag, input logic [7:0] v01, input logic [7:0] v10,
                                input logic [7:0] v11);
    logic [7:0] e;
    for (int k = 0; k < NUM_CH; k++) begin
      case (fg[k])
        2'b01: e = v01;
        2'b10: e = v10;
        2'b11: e = v11;
        default: e = 8'h00;
      endcase
      chk(tag, k, sig[k*8 +: 8], e);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < NUM_CH; k++) begin
      fg[k] = 2'(k % 4); m_reg[k] = '0; m_acc[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NUM_CH; k++) chk("R1 reset", k, sig[k*8 +: 8], 8'h00);

    // R2 R3: mode decode and bit placement, 24-frame and 12-frame superframes
    esf = 1'b1;
    run_sf(1, 0, -1, -1, -1, -1, -1, "R2 esf ones");
    for (int k = 0; k < NUM_CH; k++) chk("R2 esf ones", k, sig[k*8 +: 8], exp_ones(fg[k], 1'b1));
    esf = 1'b0;
    run_sf(1, 0, -1, -1, -1, -1, -1, "R3 sf ones");
    for (int k = 0; k < NUM_CH; k++) chk("R3 sf ones", k, sig[k*8 +: 8], exp_ones(fg[k], 1'b0));
    esf = 1'b1;
    run_sf(1, 0, -1, -1, -1, -1, -1, "R4 esf ones");
    expect_pattern("R4 esf ones", 8'h08, 8'h0C, 8'h0F);

    // R7: framing error at frame 0 holds through frame 8 of the next superframe
    run_sf(0, 0, 0, 5, -1, -1, -1, "R7 err");
    expect_pattern("R7 err hold", 8'h08, 8'h0C, 8'h0F);
    run_sf(0, 0, -1, -1, -1, -1, -1, "R7 err release");
    expect_pattern("R7 err release", 8'h08, 8'h00, 8'h00);

    // R7: slip retriggers the hold late in the superframe
    run_sf(1, 0, -1, -1, -1, -1, -1, "R4 refill");
    run_sf(0, 0, 0, 5, 20, 5, -1, "R7 retrig");
    expect_pattern("R7 retrig", 8'h08, 8'h0C, 8'h0F);
    run_sf(0, 0, -1, -1, -1, -1, -1, "R7 retrig hold");
    expect_pattern("R7 retrig hold", 8'h08, 8'h0C, 8'h0F);
    run_sf(0, 0, -1, -1, -1, -1, -1, "R7 retrig end");
    expect_pattern("R7 retrig end", 8'h00, 8'h00, 8'h00);

    // R6: software hold, and release without a counted hold
    run_sf(1, 0, -1, -1, -1, -1, -1, "R4 refill");
    sw = 1'b1;
    run_sf(0, 0, -1, -1, -1, -1, -1, "R6 sw hold");
    expect_pattern("R6 sw hold", 8'h08, 8'h0C, 8'h0F);
    sw = 1'b0;
    run_sf(0, 0, -1, -1, -1, -1, -1, "R6 sw release");
    expect_pattern("R6 sw release", 8'h00, 8'h00, 8'h00);

    // R5: superframe alignment lost during frame 1
    run_sf(1, 0, -1, -1, -1, -1, -1, "R4 refill");
    run_sf(0, 0, -1, -1, -1, -1, 1, "R5 misalign");
    expect_pattern("R5 misalign", 8'h08, 8'h0C, 8'h0F);
    run_sf(0, 0, -1, -1, -1, -1, -1, "R5 realign");
    expect_pattern("R5 realign", 8'h08, 8'h00, 8'h00);

    // R8: common-channel mode, 24 then 12 frames
    ccs = 1'b1;
    run_sf(3, 8'hA0, -1, -1, -1, -1, -1, "R8 ccs esf");
    for (int k = 0; k < NUM_CH; k++) chk("R8 ccs esf", k, sig[k*8 +: 8], 8'hA0 + 8'(k));
    esf = 1'b0;
    run_sf(3, 8'h50, -1, -1, -1, -1, -1, "R8 ccs sf");
    for (int k = 0; k < NUM_CH; k++)
      chk("R8 ccs sf", k, sig[k*8 +: 8], (k < 12) ? 8'h50 + 8'(k) : 8'hA0 + 8'(k));
    ccs = 1'b0;

    // random mix: R4 timing under all gates
    p_ev = 5;
    for (int s = 0; s < 36; s++) begin
      esf = 1'($urandom);
      ccs = (($urandom % 4) == 0);
      sw  = (($urandom % 8) == 0);
      for (int k = 0; k < NUM_CH; k++) fg[k] = 2'($urandom);
      run_sf(2, 0, -1, -1, -1, -1, -1, "R4 random");
    end
    p_ev = 0; sw = 1'b0; ccs = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule